// File: doc/BRIEF.md
# Strided Vector Operand Address Generator

This block turns a vector operand descriptor into the stream of memory addresses a memory-to-memory vector datapath needs for that operand. A single-cycle start pulse captures a base address, an offset with a direction bit that decides whether the offset is added to or taken away from the base, a stride, and an element count. From the next cycle on the block offers one element address at a time on a valid/ready output, stepping by the stride after every accepted address, and marks the final one with a last flag.

The address of the final element is worked out when the descriptor is captured and held on a separate output, so a consumer can set up bounds checks or the following operand before the stream has finished. When the stream ends the block goes back to idle and gives a one-cycle completion pulse. All address arithmetic wraps around the address width.

Top module: `vec_addr_gen`

## Requirements
- R1: A start pulse is taken only while the block is idle; the descriptor is captured in that cycle, and a start pulse or descriptor input change while a stream is active has no effect on the addresses, the last flag or the end address.
- R2: The first address offered is base plus offset when the direction input is 0 and base minus offset when it is 1, modulo 2^24.
- R3: Each further address equals the previous one plus the stride, the stride taken as a 24-bit two's complement value, modulo 2^24.
- R4: For a nonzero length N, exactly N addresses are handed over, one on each clock edge where valid and ready are both high.
- R5: While valid is high and ready is low, the address and the last flag hold their values and valid stays high.
- R6: The last flag is high together with the N-th address only; the cycle after that address is taken, valid is low and done is high for exactly one cycle.
- R7: A start with length 0 offers no address; done is high in the cycle after the start and low in the cycle after that.
- R8: From the cycle after an accepted start until the next accepted start, the end-address output equals first address plus (N-1) times the stride modulo 2^24, or the first address when N is 0.
- R9: After reset, valid, last and done are low and the address and end-address outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new stream with the present descriptor |
| base_i | input | 24 | Base address |
| offset_i | input | 24 | Unsigned offset applied to the base |
| sub_i | input | 1 | 0 adds the offset, 1 subtracts it |
| stride_i | input | 24 | Two's complement step between element addresses |
| len_i | input | 16 | Number of elements |
| addr_o | output | 24 | Current element address |
| addr_valid_o | output | 1 | Address output holds a pending element |
| addr_ready_i | input | 1 | Consumer takes the address on this edge |
| addr_last_o | output | 1 | Current address is the final element |
| end_addr_o | output | 24 | Address of the final element of the current descriptor |
| done_o | output | 1 | One-cycle pulse when a stream completes |

## Verification
Descriptors are chosen so that an added offset, a subtracted offset that wraps below zero, a negative stride, a zero stride and a single-element length each produce streams that a wrong sign, a missing wrap or an off-by-one count would change. The same streams are run with the consumer always ready and with irregular ready patterns, which separates correct stall holding from an address that advances on valid alone. A start pulse and scrambled descriptor inputs during an active stream show whether capture is limited to idle, and a zero-length start shows the empty case completing without any address.

// File: rtl/vag_pkg.sv
package vag_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned LEN_W  = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/vag_plan.sv
// Descriptor arithmetic: effective first address and the final element address.
module vag_plan #(
  parameter int unsigned AW = vag_pkg::ADDR_W,
  parameter int unsigned LW = vag_pkg::LEN_W
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] offset_i,
  input  logic          sub_i,
  input  logic [AW-1:0] stride_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);
  logic [AW-1:0] len_ext;
  logic [AW-1:0] steps;

  always_comb begin
    len_ext = AW'(len_i);
    steps   = (len_i == '0) ? '0 : (len_ext - AW'(1));
    first_o = sub_i ? (base_i - offset_i) : (base_i + offset_i);
    final_o = first_o + (steps * stride_i);
  end

  initial begin
    assert (LW <= AW) else $error("length width must not exceed address width");
  end
endmodule

// File: rtl/vag_walk.sv
// Element sequencer: steps the address by the stride per handshake and counts elements.
module vag_walk #(
  parameter int unsigned AW = vag_pkg::ADDR_W,
  parameter int unsigned LW = vag_pkg::LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] stride_i,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          done_o,
  output logic          accept_o
);
  import vag_pkg::*;

  walk_st_e      state_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_q;
  logic [LW-1:0] left_q;
  logic          last_q;
  logic          done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q   <= first_i;
            stride_q <= stride_i;
            left_q   <= len_i;
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              last_q  <= (len_i == LW'(1));
            end
          end
        end
        ST_RUN: begin
          if (ready_i) begin
            if (last_q) begin
              state_q <= ST_IDLE;
              last_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              addr_q <= addr_q + stride_q;
              left_q <= left_q - LW'(1);
              last_q <= (left_q == LW'(2));
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = (state_q == ST_RUN);
  assign last_o  = last_q;
  assign done_o  = done_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(last_o)); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && last_o |=> done_o && !valid_o); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o); // R6

  AST_EMPTY_STREAM: assert property (@(posedge clk) disable iff (rst)
    start_i && !valid_o && (len_i == '0) |=> done_o && !valid_o); // R7

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    valid_o && start_i && !ready_i |=> valid_o && $stable(addr_o)); // R1
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int unsigned AW = vag_pkg::ADDR_W,
  parameter int unsigned LW = vag_pkg::LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] offset_i,
  input  logic          sub_i,
  input  logic [AW-1:0] stride_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic          addr_last_o,
  output logic [AW-1:0] end_addr_o,
  output logic          done_o
);
  logic [AW-1:0] first_w;
  logic [AW-1:0] final_w;
  logic          accept_w;
  logic [AW-1:0] end_q;

  vag_plan #(.AW(AW), .LW(LW)) plan_i (
    .base_i   (base_i),
    .offset_i (offset_i),
    .sub_i    (sub_i),
    .stride_i (stride_i),
    .len_i    (len_i),
    .first_o  (first_w),
    .final_o  (final_w)
  );

  vag_walk #(.AW(AW), .LW(LW)) walk_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .len_i    (len_i),
    .first_i  (first_w),
    .stride_i (stride_i),
    .ready_i  (addr_ready_i),
    .addr_o   (addr_o),
    .valid_o  (addr_valid_o),
    .last_o   (addr_last_o),
    .done_o   (done_o),
    .accept_o (accept_w)
  );

  always_ff @(posedge clk) begin
    if (rst)           end_q <= '0;
    else if (accept_w) end_q <= final_w;
  end

  assign end_addr_o = end_q;

  AST_LAST_MEETS_END: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o && addr_last_o |-> addr_o == end_addr_o); // R8

  AST_END_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o && $past(addr_valid_o) |-> $stable(end_addr_o)); // R1
endmodule

// File: tb/vec_addr_gen_tb_top.sv
module vec_addr_gen_tb_top;
  localparam int AW = 24;
  localparam int LW = 16;
  localparam int NV = 6;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] off;
    logic          sub;
    logic [AW-1:0] stride;
    logic [LW-1:0] len;
    logic [7:0]    rdy;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{24'h001000, 24'h000020, 1'b0, 24'h000004, 16'd5, 8'hFF},
    '{24'h000010, 24'h000020, 1'b1, 24'h000008, 16'd4, 8'hFF},
    '{24'h800000, 24'h000000, 1'b0, 24'hFFFFFC, 16'd3, 8'b1011_0110},
    '{24'h123456, 24'h000100, 1'b1, 24'h000000, 16'd3, 8'b0101_0101},
    '{24'hABCDEF, 24'h000001, 1'b0, 24'h000010, 16'd1, 8'b1100_0000},
    '{24'h000000, 24'h000000, 1'b0, 24'h000100, 16'd6, 8'b1001_1101}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] offset_i = '0;
  logic          sub_i = 1'b0;
  logic [AW-1:0] stride_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          addr_ready_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          addr_valid_o;
  logic          addr_last_o;
  logic [AW-1:0] end_addr_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vec_addr_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .base_i       (base_i),
    .offset_i     (offset_i),
    .sub_i        (sub_i),
    .stride_i     (stride_i),
    .len_i        (len_i),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .addr_last_o  (addr_last_o),
    .end_addr_o   (end_addr_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [AW-1:0] first;
    logic [AW-1:0] exp_end;
    logic [AW-1:0] exp_addr;
    int got;
    int cyc;
    bit poked;
    bit stalled;
    bit rdy;
    first = v.sub ? (v.base - v.off) : (v.base + v.off);
    exp_end = first;
    for (int k = 1; k < int'(v.len); k++) exp_end = exp_end + v.stride;
    @(negedge clk);
    start_i = 1'b1; base_i = v.base; offset_i = v.off; sub_i = v.sub;
    stride_i = v.stride; len_i = v.len; addr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    base_i = ~v.base; offset_i = v.off + 24'h55; sub_i = ~v.sub;
    stride_i = v.stride + 24'h3; len_i = v.len + 16'd7;
    chk(end_addr_o == exp_end, "R8 end address", 32'(end_addr_o), 32'(exp_end));
    exp_addr = first; got = 0; cyc = 0; poked = 1'b0; stalled = 1'b0;
    while (got < int'(v.len) && cyc < 200) begin
      rdy = v.rdy[cyc % 8];
      addr_ready_i = rdy;
      if (got == 1 && !poked) begin start_i = 1'b1; poked = 1'b1; end
      else start_i = 1'b0;
      chk(addr_valid_o == 1'b1, stalled ? "R5 valid held" : "R4 valid", 32'(addr_valid_o), 32'd1);
      chk(addr_o == exp_addr, stalled ? "R5 address held" : (got == 0 ? "R2 first address" : "R3 stride step"),
          32'(addr_o), 32'(exp_addr));
      chk(addr_last_o == (got == int'(v.len) - 1), "R6 last flag", 32'(addr_last_o),
          32'(got == int'(v.len) - 1));
      if (addr_valid_o && rdy) begin
        got++; exp_addr = exp_addr + v.stride; stalled = 1'b0;
      end else begin
        stalled = 1'b1;
      end
      @(negedge clk);
      cyc++;
    end
    addr_ready_i = 1'b0; start_i = 1'b0;
    chk(got == int'(v.len), "R4 element count", 32'(got), 32'(v.len));
    chk(done_o == 1'b1 && addr_valid_o == 1'b0, "R6 done after last", {done_o, addr_valid_o}, 32'b10);
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done one cycle", 32'(done_o), 32'd0);
    chk(end_addr_o == exp_end, "R1 end unchanged by busy inputs", 32'(end_addr_o), 32'(exp_end));
    chk(addr_valid_o == 1'b0, "R1 busy start ignored", 32'(addr_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(addr_valid_o == 1'b0 && addr_last_o == 1'b0 && done_o == 1'b0, "R9 reset flags",
        {addr_valid_o, addr_last_o, done_o}, 32'd0);
    chk(addr_o == '0 && end_addr_o == '0, "R9 reset addresses", 32'(addr_o | end_addr_o), 32'd0);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R7 zero length
    @(negedge clk);
    start_i = 1'b1; base_i = 24'h000400; offset_i = 24'h10; sub_i = 1'b0;
    stride_i = 24'h4; len_i = '0; addr_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1 && addr_valid_o == 1'b0, "R7 empty done", {done_o, addr_valid_o}, 32'b10);
    chk(end_addr_o == 24'h000410, "R8 empty end address", 32'(end_addr_o), 32'h410);
    @(negedge clk);
    chk(done_o == 1'b0 && addr_valid_o == 1'b0, "R7 empty no address", {done_o, addr_valid_o}, 32'd0);

    // R9 reset in the middle of a stream
    start_i = 1'b1; len_i = 16'd4; addr_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(addr_valid_o == 1'b0 && end_addr_o == '0, "R9 reset mid stream",
        {addr_valid_o, 8'h0, end_addr_o}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule